// File: doc/BRIEF.md
# NAND command and address cycle sequencer

This block produces the command and address phases of one raw NAND flash operation at a time. A request names the operation, a column and a row address. While the block is idle, a one-cycle start pulse latches the request. The block then drives a series of cycles on an 8-bit bus: a first command, zero or more address bytes, and an optional second command. Each cycle lasts exactly one clock. After the last cycle, the block returns to idle and pulses done.

Three configuration inputs decide how the address phase is built:
- the page-size mode (512-byte pages or large pages),
- a three-level capacity tier,
- the data-bus width (8-bit or 16-bit).

Together they set how many address bytes are sent and how the column and row are packed into them. Data transfer and ECC are handled elsewhere; this block stops once the final command cycle has been issued.

Operation codes on `op_i`:

| Code | Operation |
|------|-----------|
| 0 | page read |
| 1 | spare-area read |
| 2 | random data out |
| 3 | program |
| 4 | block erase |
| 5 | read ID |
| 6 | status |
| 7 | reset |

Capacity tier on `tier_i`: 0 is the smallest device, 1 the middle size, and 2 or 3 the largest.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `cyc_valid_o` are all 0.
- R2: `start_i` is accepted only while the block is idle. A start pulse during an operation changes neither that operation's cycles nor anything afterwards: no extra cycles appear after its done.
- R3: Every emitted cycle has `cyc_valid_o`=1 for one clock, with exactly one of `cyc_cle_o` (command) or `cyc_ale_o` (address) set. The cycles begin on the clock after start is accepted, and `busy_o` is high for exactly those cycles. `done_o` pulses for one clock on the cycle after the last one, with `busy_o` low.
- R4: Cycle order is always: first command, then the address bytes, then the second command if the operation has one.
- R5: In large-page mode, read, spare read, random out and program send 3, 4 or 5 address bytes for tier 0, 1 or 2/3.
- R6: In 512-byte-page mode, read, spare read, random out and program send 2, 3 or 4 address bytes for tier 0, 1 or 2/3.
- R7: Erase sends command 0x60, then row bytes only, least significant first (1, 2 or 3 of them for tier 0, 1 or 2/3, in either page mode), then confirm command 0xD0.
- R8: Large-page packing is: column bits 7:0, then column bits 11:8 zero-extended, then row bits 7:0, then row bits 15:8, then row bits 23:16.
- R9: 512-byte-page packing is: column bits 7:0, then row bits 7:0, row bits 15:8, row bits 23:16.
- R10: With `bus16_i`=1, the column is shifted right by one before packing for read, spare read, random out and program. Read ID sends 0x90 and exactly one address byte, equal to `col_i[7:0]`, with no halving.
- R11: Read sends 0x00. In large-page mode, the address is followed by 0x30; in 512-byte mode there is no second command. Spare read sends 0x50 with no second command in 512-byte mode. In large-page mode, spare read sends 0x00, uses column SPARE_COL in place of `col_i`, and then sends 0x30. Random out sends 0x05, followed by 0xE0 in large-page mode only.
- R12: Program sends 0x80, the address, then 0x10, in both page modes.
- R13: Status sends only 0x70 and reset only 0xFF: one command cycle and no address cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse; taken only when idle |
| op_i | input | 3 | Operation code (see table above) |
| large_page_i | input | 1 | 1 = large-page mode, 0 = 512-byte pages |
| bus16_i | input | 1 | 1 = 16-bit data bus |
| tier_i | input | 2 | Capacity tier: 0, 1, or 2/3 for the largest |
| col_i | input | 12 | Column address |
| row_i | input | 24 | Row (page) address |
| busy_o | output | 1 | An operation is emitting cycles |
| done_o | output | 1 | One-clock pulse after the last cycle |
| cyc_valid_o | output | 1 | A bus cycle is present this clock |
| cyc_cle_o | output | 1 | The cycle is a command |
| cyc_ale_o | output | 1 | The cycle is an address byte |
| cyc_data_o | output | 8 | Command or address byte |

## Verification
The bench builds the block with its default SPARE_COL of 2048. This makes the large-page spare read send column bytes 0x00 and 0x08. The table varies the tier, page mode and bus width across every operation code, so each address count and each packing rule is reached with distinct column and row bytes. A directed run fires a second start in the middle of an operation and checks that nothing changes.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int COL_W    = 12;
  localparam int ROW_W    = 24;
  localparam int BYTE_W   = 8;
  localparam int ADDR_MAX = 5;
  localparam int CNT_W    = $clog2(ADDR_MAX + 1);
  localparam int TIER_W   = 2;
  localparam int OP_W     = 3;

  typedef enum logic [OP_W-1:0] {
    OP_READ  = 3'd0,
    OP_SPARE = 3'd1,
    OP_RNDO  = 3'd2,
    OP_PROG  = 3'd3,
    OP_ERASE = 3'd4,
    OP_ID    = 3'd5,
    OP_STAT  = 3'd6,
    OP_RST   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    AK_NONE  = 2'd0,
    AK_RW    = 2'd1,
    AK_ERASE = 2'd2,
    AK_ID    = 2'd3
  } addr_kind_e;

  typedef struct packed {
    logic [BYTE_W-1:0] cmd1;
    logic [BYTE_W-1:0] cmd2;
    logic              has_cmd2;
    addr_kind_e        kind;
    logic              use_spare;
  } op_info_t;
endpackage

// File: rtl/nand_op_decode.sv
module nand_op_decode
  import nand_seq_pkg::*;
(
  input  op_e      op_i,
  input  logic     large_i,
  output op_info_t info_o
);
  always_comb begin
    info_o.cmd1      = 8'h00;
    info_o.cmd2      = 8'h00;
    info_o.has_cmd2  = 1'b0;
    info_o.kind      = AK_NONE;
    info_o.use_spare = 1'b0;
    unique case (op_i)
      OP_READ: begin
        info_o.kind     = AK_RW;
        info_o.cmd2     = 8'h30;
        info_o.has_cmd2 = large_i;
      end
      OP_SPARE: begin
        info_o.kind      = AK_RW;
        info_o.cmd1      = large_i ? 8'h00 : 8'h50;
        info_o.cmd2      = 8'h30;
        info_o.has_cmd2  = large_i;
        info_o.use_spare = large_i;
      end
      OP_RNDO: begin
        info_o.kind     = AK_RW;
        info_o.cmd1     = 8'h05;
        info_o.cmd2     = 8'hE0;
        info_o.has_cmd2 = large_i;
      end
      OP_PROG: begin
        info_o.kind     = AK_RW;
        info_o.cmd1     = 8'h80;
        info_o.cmd2     = 8'h10;
        info_o.has_cmd2 = 1'b1;
      end
      OP_ERASE: begin
        info_o.kind     = AK_ERASE;
        info_o.cmd1     = 8'h60;
        info_o.cmd2     = 8'hD0;
        info_o.has_cmd2 = 1'b1;
      end
      OP_ID: begin
        info_o.kind = AK_ID;
        info_o.cmd1 = 8'h90;
      end
      OP_STAT: info_o.cmd1 = 8'h70;
      OP_RST:  info_o.cmd1 = 8'hFF;
      default: info_o.cmd1 = 8'hFF;
    endcase
  end
endmodule

// File: rtl/nand_addr_pack.sv
module nand_addr_pack
  import nand_seq_pkg::*;
#(
  parameter int SPARE_COL = 2048
) (
  input  addr_kind_e                         kind_i,
  input  logic                               large_i,
  input  logic                               bus16_i,
  input  logic                               use_spare_i,
  input  logic [TIER_W-1:0]                  tier_i,
  input  logic [COL_W-1:0]                   col_i,
  input  logic [ROW_W-1:0]                   row_i,
  output logic [ADDR_MAX-1:0][BYTE_W-1:0]    bytes_o,
  output logic [CNT_W-1:0]                   cnt_o
);
  logic [COL_W-1:0] col_src, col_eff;
  logic [CNT_W-1:0] tier_c;

  always_comb begin
    col_src = use_spare_i ? COL_W'(SPARE_COL) : col_i;
    col_eff = (bus16_i && kind_i == AK_RW) ? (col_src >> 1) : col_src;
    tier_c  = (tier_i > 2'd2) ? CNT_W'(2) : CNT_W'(tier_i);
    bytes_o = '0;
    cnt_o   = '0;
    unique case (kind_i)
      AK_RW: begin
        if (large_i) begin
          bytes_o[0] = col_eff[7:0];
          bytes_o[1] = BYTE_W'(col_eff >> 8);
          bytes_o[2] = row_i[7:0];
          bytes_o[3] = row_i[15:8];
          bytes_o[4] = row_i[23:16];
          cnt_o      = CNT_W'(3) + tier_c;
        end else begin
          bytes_o[0] = col_eff[7:0];
          bytes_o[1] = row_i[7:0];
          bytes_o[2] = row_i[15:8];
          bytes_o[3] = row_i[23:16];
          cnt_o      = CNT_W'(2) + tier_c;
        end
      end
      AK_ERASE: begin
        bytes_o[0] = row_i[7:0];
        bytes_o[1] = row_i[15:8];
        bytes_o[2] = row_i[23:16];
        cnt_o      = CNT_W'(1) + tier_c;
      end
      AK_ID: begin
        bytes_o[0] = col_i[7:0];
        cnt_o      = CNT_W'(1);
      end
      default: cnt_o = '0;
    endcase
  end
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int SPARE_COL = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic              large_page_i,
  input  logic              bus16_i,
  input  logic [TIER_W-1:0] tier_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [ROW_W-1:0]  row_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cyc_valid_o,
  output logic              cyc_cle_o,
  output logic              cyc_ale_o,
  output logic [BYTE_W-1:0] cyc_data_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_CMD1, ST_ADDR, ST_CMD2} st_e;

  st_e                             st_q, st_d;
  op_e                             op_q;
  logic                            lp_q, b16_q;
  logic [TIER_W-1:0]               tier_q;
  logic [COL_W-1:0]                col_q;
  logic [ROW_W-1:0]                row_q;
  logic [CNT_W-1:0]                idx_q, idx_d;
  logic                            done_q, done_d;
  op_info_t                        info;
  logic [ADDR_MAX-1:0][BYTE_W-1:0] abytes;
  logic [CNT_W-1:0]                acnt;
  logic                            accept;

  nand_op_decode u_dec (
    .op_i    (op_q),
    .large_i (lp_q),
    .info_o  (info)
  );

  nand_addr_pack #(.SPARE_COL(SPARE_COL)) u_pack (
    .kind_i      (info.kind),
    .large_i     (lp_q),
    .bus16_i     (b16_q),
    .use_spare_i (info.use_spare),
    .tier_i      (tier_q),
    .col_i       (col_q),
    .row_i       (row_q),
    .bytes_o     (abytes),
    .cnt_o       (acnt)
  );

  assign accept = start_i && (st_q == ST_IDLE);

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = ST_CMD1;
      ST_CMD1: begin
        idx_d = '0;
        if (acnt != '0)        st_d = ST_ADDR;
        else if (info.has_cmd2) st_d = ST_CMD2;
        else begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      ST_ADDR: begin
        if (idx_q == acnt - CNT_W'(1)) begin
          if (info.has_cmd2) st_d = ST_CMD2;
          else begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        end else begin
          idx_d = idx_q + CNT_W'(1);
        end
      end
      ST_CMD2: begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
      op_q   <= OP_RST;
      lp_q   <= 1'b0;
      b16_q  <= 1'b0;
      tier_q <= '0;
      col_q  <= '0;
      row_q  <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      done_q <= done_d;
      if (accept) begin
        op_q   <= op_e'(op_i);
        lp_q   <= large_page_i;
        b16_q  <= bus16_i;
        tier_q <= tier_i;
        col_q  <= col_i;
        row_q  <= row_i;
      end
    end
  end

  always_comb begin
    unique case (st_q)
      ST_CMD1: cyc_data_o = info.cmd1;
      ST_CMD2: cyc_data_o = info.cmd2;
      ST_ADDR: cyc_data_o = abytes[idx_q];
      default: cyc_data_o = '0;
    endcase
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign cyc_valid_o = busy_o;
  assign cyc_cle_o   = (st_q == ST_CMD1) || (st_q == ST_CMD2);
  assign cyc_ale_o   = (st_q == ST_ADDR);
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       cyc_valid_o,
  input logic       cyc_cle_o,
  input logic       cyc_ale_o,
  input logic [7:0] cyc_data_o
);
  assert_one_qual_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o |-> $onehot({cyc_cle_o, cyc_ale_o}));

  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cyc_valid_o && !cyc_cle_o && !cyc_ale_o);

  assert_done_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_follows_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));

  assert_addr_after_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_ale_o |-> $past(cyc_valid_o));

  assert_start_when_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_cmd_only_status_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_cle_o && (cyc_data_o == 8'h70)) |=> !cyc_ale_o);
endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .cyc_valid_o (cyc_valid_o),
  .cyc_cle_o   (cyc_cle_o),
  .cyc_ale_o   (cyc_ale_o),
  .cyc_data_o  (cyc_data_o)
);

// File: tb/tb_nand_cmd_seq.sv
module tb_nand_cmd_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic        large_page_i = 1'b0;
  logic        bus16_i = 1'b0;
  logic [1:0]  tier_i = '0;
  logic [11:0] col_i = '0;
  logic [23:0] row_i = '0;
  logic        busy_o, done_o, cyc_valid_o, cyc_cle_o, cyc_ale_o;
  logic [7:0]  cyc_data_o;

  always #2 clk_i = ~clk_i;

  nand_cmd_seq dut (.*);

  typedef struct packed {
    logic [2:0]       op;
    logic             lp;
    logic             b16;
    logic [1:0]       tier;
    logic [2:0]       n;
    logic [0:6][8:0]  exp;
  } vec_t;

  localparam int NV = 16;
  // exp entries: {cle, byte}; col 0x5E7, row 0xC3B2A1
  localparam vec_t VECS [NV] = '{
    '{3'd0,1'b1,1'b0,2'd2,3'd7,{9'h100,9'h0E7,9'h005,9'h0A1,9'h0B2,9'h0C3,9'h130}},
    '{3'd0,1'b1,1'b1,2'd0,3'd5,{9'h100,9'h0F3,9'h002,9'h0A1,9'h130,9'h000,9'h000}},
    '{3'd0,1'b0,1'b0,2'd3,3'd5,{9'h100,9'h0E7,9'h0A1,9'h0B2,9'h0C3,9'h000,9'h000}},
    '{3'd0,1'b0,1'b0,2'd0,3'd3,{9'h100,9'h0E7,9'h0A1,9'h000,9'h000,9'h000,9'h000}},
    '{3'd3,1'b1,1'b0,2'd1,3'd6,{9'h180,9'h0E7,9'h005,9'h0A1,9'h0B2,9'h110,9'h000}},
    '{3'd3,1'b0,1'b1,2'd1,3'd5,{9'h180,9'h0F3,9'h0A1,9'h0B2,9'h110,9'h000,9'h000}},
    '{3'd4,1'b1,1'b0,2'd2,3'd5,{9'h160,9'h0A1,9'h0B2,9'h0C3,9'h1D0,9'h000,9'h000}},
    '{3'd4,1'b0,1'b0,2'd0,3'd3,{9'h160,9'h0A1,9'h1D0,9'h000,9'h000,9'h000,9'h000}},
    '{3'd5,1'b1,1'b1,2'd2,3'd2,{9'h190,9'h0E7,9'h000,9'h000,9'h000,9'h000,9'h000}},
    '{3'd6,1'b1,1'b0,2'd2,3'd1,{9'h170,9'h000,9'h000,9'h000,9'h000,9'h000,9'h000}},
    '{3'd7,1'b0,1'b0,2'd1,3'd1,{9'h1FF,9'h000,9'h000,9'h000,9'h000,9'h000,9'h000}},
    '{3'd1,1'b1,1'b0,2'd1,3'd6,{9'h100,9'h000,9'h008,9'h0A1,9'h0B2,9'h130,9'h000}},
    '{3'd1,1'b0,1'b0,2'd0,3'd3,{9'h150,9'h0E7,9'h0A1,9'h000,9'h000,9'h000,9'h000}},
    '{3'd2,1'b1,1'b0,2'd0,3'd5,{9'h105,9'h0E7,9'h005,9'h0A1,9'h1E0,9'h000,9'h000}},
    '{3'd2,1'b0,1'b0,2'd1,3'd4,{9'h105,9'h0E7,9'h0A1,9'h0B2,9'h000,9'h000,9'h000}},
    '{3'd4,1'b1,1'b0,2'd1,3'd4,{9'h160,9'h0A1,9'h0B2,9'h1D0,9'h000,9'h000,9'h000}}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1:    return "R5 R8 R10 R11";
      2, 3:    return "R6 R9 R11";
      4, 5:    return "R12 R5 R6 R10";
      6, 7, 15: return "R7";
      8:       return "R10";
      9, 10:   return "R13";
      11, 12:  return "R11";
      default: return "R11 R4";
    endcase
  endfunction

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [8:0] got [8];
  int got_n;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic lp, input logic b16,
                        input logic [1:0] tier, input bit inject);
    int cyc;
    @(negedge clk_i);
    op_i = op; large_page_i = lp; bus16_i = b16; tier_i = tier;
    col_i = 12'h5E7; row_i = 24'hC3B2A1; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    got_n = 0;
    cyc = 0;
    while (!done_o && cyc < 40) begin
      if (cyc_valid_o && got_n < 8) begin
        got[got_n] = {cyc_cle_o, cyc_data_o};
        got_n++;
      end
      if (inject && cyc == 1) begin
        start_i = 1'b1; op_i = 3'd6;
      end
      if (inject && cyc == 2) start_i = 1'b0;
      cyc++;
      @(negedge clk_i);
    end
    check(done_o == 1'b1 && busy_o == 1'b0, "R3 done pulse with busy low", {done_o, busy_o}, 2);
    @(negedge clk_i);
    check(done_o == 1'b0, "R3 done single cycle", done_o, 0);
  endtask

  task automatic compare(input vec_t v, input string tag);
    check(got_n == int'(v.n), {tag, " R4 cycle count"}, got_n, v.n);
    for (int k = 0; k < 7; k++) begin
      if (k < int'(v.n) && k < got_n)
        check(got[k] == v.exp[k], {tag, " R4 cycle content"}, got[k], v.exp[k]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(busy_o == 0 && done_o == 0 && cyc_valid_o == 0, "R1 reset outputs", {busy_o, done_o, cyc_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(busy_o == 0 && cyc_valid_o == 0, "R1 idle after reset", {busy_o, cyc_valid_o}, 0);

    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i].op, VECS[i].lp, VECS[i].b16, VECS[i].tier, 1'b0);
      compare(VECS[i], tag_of(i));
    end

    // R2: start during busy is ignored
    run_op(VECS[0].op, VECS[0].lp, VECS[0].b16, VECS[0].tier, 1'b1);
    compare(VECS[0], "R2");
    for (int k = 0; k < 4; k++) begin
      check(cyc_valid_o == 0 && busy_o == 0, "R2 no extra operation", {cyc_valid_o, busy_o}, 0);
      @(negedge clk_i);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule